// File: doc/BRIEF.md
# Stall-Coupled Streaming Window Convolver

This block computes a stride-1, valid-mode two-dimensional convolution of a square image against a square kernel. It sits between a valid/ready input stream and a valid/ready output stream. Pixels enter one per beat in raster order, top row first and left to right within a row. Each time the most recent pixel completes a full kernel window, the block produces one result. The last result of an image carries an end-of-frame flag, which lets the downstream receiver close its transfer. The kernel weights arrive as one flat parallel vector. A synchronous soft reset clears the pipeline.

The block has no skid buffer and no FIFO. The input ready is the output ready, unchanged. The whole datapath advances on one enable, which is asserted only when an input beat transfers. So when the sink stalls, the source stalls in the same cycle, and the pipeline holds its contents until the sink is ready again. Back-pressure rules:
- A pixel is accepted only on a cycle where the input valid and the input ready are both high.
- The input ready falls in the same cycle as the output ready, and nothing else lowers it.
- While a result is offered and the sink is not ready, the result and its flags do not change.

Each tap registers its own product. The products are added only after that register, so no combinational path contains a multiplier followed by an adder.

Top module: `conv_stream_stall`

## Requirements
- R1: `s_tready` equals `m_tready` in every cycle. A pixel is accepted on a rising edge only when `s_tvalid` and `m_tready` are both high.
- R2: On an edge where no pixel is accepted, the position counters, the pixel history and the tap products keep their values. Data offered while `s_tready` is low has no effect on any later result.
- R3: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` stay stable.
- R4: Take the accepted pixel at row r and column c, each counted from 0. After its accepting edge, `m_tvalid` is high exactly when r ≥ K−1 and c ≥ K−1. An N×N image therefore yields (N−K+1)² results.
- R5: Suppose the window's top-left pixel is at (r0, c0). Then `m_tdata` is the sum, over kernel row i and kernel column j, of pixel(r0+i, c0+j) × weight slot (i·K + j). Slot s sits at bits [s·32 +: 32] of `coef_flat`. All arithmetic is unsigned and truncated to 32 bits.
- R6: `m_tlast` is high together with the result whose window ends at pixel (N−1, N−1), and it is low with every other result.
- R7: After the final pixel of an image, the counters return to row 0, column 0. The next image streams in with no reset and gives correct results.
- R8: Suppose the sink accepts a result (`m_tvalid` and `m_tready` high) on an edge where no pixel arrives. Then `m_tvalid` is low after that edge.
- R9: With `srst` high on an edge, the block afterwards shows `m_tvalid`, `m_tlast` and `m_tdata` all at 0. Any partly received image is discarded, and the next pixel is taken as row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous soft reset, active high |
| coef_flat | input | KER_K*KER_K*DATA_W | Kernel weights, slot s at bits [s*DATA_W +: DATA_W] |
| s_tvalid | input | 1 | Input pixel valid |
| s_tdata | input | DATA_W | Input pixel |
| s_tready | output | 1 | Input ready (mirrors `m_tready`) |
| m_tvalid | output | 1 | Result valid |
| m_tdata | output | DATA_W | Convolution result |
| m_tlast | output | 1 | Final result of the image |
| m_tready | input | 1 | Sink ready |

## Verification
The bound checker examines four properties on every cycle:
- the position counters are frozen on every edge that accepts no pixel;
- a result is held stable while the sink stalls;
- the end-of-frame flag appears only on a valid result, and always coincides with the counters having wrapped to the origin;
- a result consumed with no new input is retired, and the soft reset clears the outputs.

The bench's scenarios are the only place where the arithmetic values are checked. They also cover:
- which pixel positions yield a result;
- 32-bit truncation of large products;
- that pixels offered during a stall are never absorbed;
- that a second image runs correctly without a reset, including after a reset in mid-image.

// File: rtl/conv_stream_pkg.sv
package conv_stream_pkg;
  // Distance, in accepted pixels, from the newest pixel back to the window
  // element at kernel row krow / kernel column kcol.
  function automatic int tap_age(input int krow, input int kcol,
                                 input int img_n, input int ker_k);
    return (ker_k - 1 - krow) * img_n + (ker_k - 1 - kcol);
  endfunction
endpackage

// File: rtl/pixel_history.sv
module pixel_history #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 11
) (
  input  logic                          clk,
  input  logic                          srst,
  input  logic                          en,
  input  logic [DATA_W-1:0]             din,
  output logic [DEPTH-1:0][DATA_W-1:0]  hist_q
);
  // Raster-order delay line: element 0 is the pixel accepted one beat ago.
  always_ff @(posedge clk) begin
    if (srst) begin
      hist_q <= '0;
    end else if (en) begin
      hist_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) hist_q[i] <= hist_q[i-1];
    end
  end
endmodule

// File: rtl/raster_tracker.sv
module raster_tracker #(
  parameter int IMG_N = 4,
  parameter int KER_K = 3,
  localparam int PW   = (IMG_N > 1) ? $clog2(IMG_N) : 1
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          en,
  output logic [PW-1:0] row_q,
  output logic [PW-1:0] col_q,
  output logic          win_ok,
  output logic          frame_end
);
  localparam logic [PW-1:0] EDGE  = PW'(IMG_N - 1);
  localparam logic [PW-1:0] FIRST = PW'(KER_K - 1);

  logic col_wrap;
  assign col_wrap  = (col_q == EDGE);
  assign win_ok    = (row_q >= FIRST) && (col_q >= FIRST);
  assign frame_end = col_wrap && (row_q == EDGE);

  always_ff @(posedge clk) begin
    if (srst) begin
      row_q <= '0;
      col_q <= '0;
    end else if (en) begin
      col_q <= col_wrap ? '0 : col_q + 1'b1;
      if (col_wrap) row_q <= (row_q == EDGE) ? '0 : row_q + 1'b1;
    end
  end
endmodule

// File: rtl/mac_tap.sv
module mac_tap #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              en,
  input  logic [DATA_W-1:0] pix,
  input  logic [DATA_W-1:0] coef,
  output logic [DATA_W-1:0] prod_q
);
  // The product is registered here; the summation happens downstream.
  always_ff @(posedge clk) begin
    if (srst)    prod_q <= '0;
    else if (en) prod_q <= pix * coef;
  end
endmodule

// File: rtl/conv_stream_stall.sv
module conv_stream_stall #(
  parameter int DATA_W = 32,
  parameter int IMG_N  = 4,
  parameter int KER_K  = 3
) (
  input  logic                            clk,
  input  logic                            srst,
  input  logic [KER_K*KER_K*DATA_W-1:0]   coef_flat,
  input  logic                            s_tvalid,
  input  logic [DATA_W-1:0]               s_tdata,
  output logic                            s_tready,
  output logic                            m_tvalid,
  output logic [DATA_W-1:0]               m_tdata,
  output logic                            m_tlast,
  input  logic                            m_tready
);
  import conv_stream_pkg::*;

  localparam int TAPS = KER_K * KER_K;
  localparam int HIST = (KER_K - 1) * IMG_N + KER_K - 1;
  localparam int PW   = (IMG_N > 1) ? $clog2(IMG_N) : 1;

  logic                         fire;
  logic [HIST-1:0][DATA_W-1:0]  hist_q;
  logic [TAPS-1:0][DATA_W-1:0]  win;
  logic [TAPS-1:0][DATA_W-1:0]  prod_q;
  logic [PW-1:0]                row_q, col_q;
  logic                         win_ok, frame_end;
  logic [DATA_W-1:0]            acc;

  assign s_tready = m_tready;
  assign fire     = s_tvalid && m_tready;

  pixel_history #(.DATA_W(DATA_W), .DEPTH(HIST)) u_hist (
    .clk(clk), .srst(srst), .en(fire), .din(s_tdata), .hist_q(hist_q)
  );

  raster_tracker #(.IMG_N(IMG_N), .KER_K(KER_K)) u_pos (
    .clk(clk), .srst(srst), .en(fire), .row_q(row_q), .col_q(col_q),
    .win_ok(win_ok), .frame_end(frame_end)
  );

  for (genvar kr = 0; kr < KER_K; kr++) begin : g_row
    for (genvar kc = 0; kc < KER_K; kc++) begin : g_col
      localparam int AGE  = tap_age(kr, kc, IMG_N, KER_K);
      localparam int SLOT = kr * KER_K + kc;
      if (AGE == 0) begin : g_live
        assign win[SLOT] = s_tdata;
      end else begin : g_old
        assign win[SLOT] = hist_q[AGE-1];
      end
      mac_tap #(.DATA_W(DATA_W)) u_tap (
        .clk(clk), .srst(srst), .en(fire), .pix(win[SLOT]),
        .coef(coef_flat[SLOT*DATA_W +: DATA_W]), .prod_q(prod_q[SLOT])
      );
    end
  end

  // Adder tree sits after the product registers.
  always_comb begin
    acc = '0;
    for (int t = 0; t < TAPS; t++) acc = acc + prod_q[t];
  end
  assign m_tdata = acc;

  always_ff @(posedge clk) begin
    if (srst) begin
      m_tvalid <= 1'b0;
      m_tlast  <= 1'b0;
    end else if (fire) begin
      m_tvalid <= win_ok;
      m_tlast  <= win_ok && frame_end;
    end else if (m_tready) begin
      m_tvalid <= 1'b0;
      m_tlast  <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_stream_stall_chk.sv
module conv_stream_stall_chk #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 2
) (
  input logic              clk,
  input logic              srst,
  input logic              s_tvalid,
  input logic              s_tready,
  input logic              m_tvalid,
  input logic [DATA_W-1:0] m_tdata,
  input logic              m_tlast,
  input logic              m_tready,
  input logic [ROW_W-1:0]  row_q,
  input logic [ROW_W-1:0]  col_q
);
  // R2
  freeze_chk: assert property (@(posedge clk) disable iff (srst)
    !(s_tvalid && s_tready) |=> ($stable(row_q) && $stable(col_q)));

  // R3
  hold_out_chk: assert property (@(posedge clk) disable iff (srst)
    (m_tvalid && !m_tready) |=> ($stable(m_tvalid) && $stable(m_tdata) && $stable(m_tlast)));

  // R6
  last_valid_chk: assert property (@(posedge clk) disable iff (srst)
    m_tlast |-> m_tvalid);

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (srst)
    m_tlast |-> (row_q == '0 && col_q == '0));

  // R8
  retire_chk: assert property (@(posedge clk) disable iff (srst)
    (m_tvalid && m_tready && !s_tvalid) |=> !m_tvalid);

  // R9
  clear_chk: assert property (@(posedge clk)
    srst |=> (!m_tvalid && !m_tlast && m_tdata == '0));
endmodule

bind conv_stream_stall conv_stream_stall_chk #(.DATA_W(DATA_W), .ROW_W(PW)) u_chk (
  .clk(clk), .srst(srst), .s_tvalid(s_tvalid), .s_tready(s_tready),
  .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tlast(m_tlast),
  .m_tready(m_tready), .row_q(row_q), .col_q(col_q)
);

// File: tb/conv_stream_stall_test.sv
module conv_stream_stall_test;
  localparam int W = 32;
  localparam int N = 4;
  localparam int K = 3;
  localparam int NCASE = 4;
  // Each row: pixel base, pixel step, weight base, weight step.
  localparam int unsigned CASES [NCASE][4] = '{
    '{0, 1, 0, 1},
    '{5, 3, 7, 2},
    '{65536, 1, 65536, 3},
    '{32'hFFFF_FFF0, 7, 3, 32'hFFFF_FFFF}
  };

  logic              clk = 1'b0;
  logic              srst = 1'b1;
  logic [K*K*W-1:0]  coef_flat = '0;
  logic              s_tvalid = 1'b0;
  logic [W-1:0]      s_tdata = '0;
  logic              s_tready;
  logic              m_tvalid;
  logic [W-1:0]      m_tdata;
  logic              m_tlast;
  logic              m_tready = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  conv_stream_stall #(.DATA_W(W), .IMG_N(N), .KER_K(K)) uut (
    .clk(clk), .srst(srst), .coef_flat(coef_flat), .s_tvalid(s_tvalid),
    .s_tdata(s_tdata), .s_tready(s_tready), .m_tvalid(m_tvalid),
    .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tready(m_tready)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int unsigned pix(input int cs, input int j);
    return CASES[cs][0] + CASES[cs][1] * j;
  endfunction

  function automatic int unsigned ref_out(input int cs, input int r0, input int c0);
    int unsigned acc = 0;
    for (int i = 0; i < K; i++)
      for (int j = 0; j < K; j++)
        acc += pix(cs, (r0 + i) * N + c0 + j) * (CASES[cs][2] + CASES[cs][3] * (i * K + j));
    return acc;
  endfunction

  task automatic load_coef(input int cs);
    for (int s = 0; s < K * K; s++)
      coef_flat[s*W +: W] = CASES[cs][2] + CASES[cs][3] * s;
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic send_beat(input logic [W-1:0] d);
    s_tvalid = 1'b1;
    s_tdata  = d;
    m_tready = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_image(input int cs, input bit gaps, input bit stall);
    load_coef(cs);
    for (int j = 0; j < N * N; j++) begin
      int r = j / N;
      int c = j % N;
      bit ok = (r >= K - 1) && (c >= K - 1);
      send_beat(pix(cs, j));
      chk("R4 valid", {31'b0, m_tvalid}, {31'b0, ok});
      if (ok) begin
        chk((cs > 0 && j == N * (K - 1) + K - 1) ? "R7 first result" : "R5 data",
            m_tdata, ref_out(cs, r - K + 1, c - K + 1));
        chk("R6 last", {31'b0, m_tlast}, {31'b0, j == N * N - 1});
      end
      if (stall && ok && j < N * N - 1) begin
        logic [W-1:0] held = m_tdata;
        m_tready = 1'b0;
        s_tdata  = 32'hDEAD_BEEF;
        for (int t = 0; t < 3; t++) begin
          @(negedge clk);
          chk("R1 ready mirrors sink", {31'b0, s_tready}, 32'd0);
          chk("R3 valid held", {31'b0, m_tvalid}, 32'd1);
          chk("R3 data held", m_tdata, held);
        end
        m_tready = 1'b1;
      end
      if (gaps) begin
        s_tvalid = 1'b0;
        @(negedge clk);
        chk("R8 retired", {31'b0, m_tvalid}, 32'd0);
      end
    end
    s_tvalid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset valid", {31'b0, m_tvalid}, 32'd0);
    chk("R9 reset data", m_tdata, 32'd0);
    chk("R9 reset last", {31'b0, m_tlast}, 32'd0);
    srst = 1'b0;
    m_tready = 1'b0;
    #1 chk("R1 ready low", {31'b0, s_tready}, 32'd0);
    m_tready = 1'b1;
    #1 chk("R1 ready high", {31'b0, s_tready}, 32'd1);
    @(negedge clk);

    // Table walk: images back to back, no reset in between (R7).
    for (int cs = 0; cs < NCASE; cs++)
      run_image(cs, cs == 1, cs == 2);

    // Reset in mid-image, then a clean image (R9, R2).
    load_coef(1);
    for (int j = 0; j < 11; j++) send_beat(pix(1, j));
    s_tvalid = 1'b0;
    srst = 1'b1;
    @(negedge clk);
    srst = 1'b0;
    chk("R9 mid reset valid", {31'b0, m_tvalid}, 32'd0);
    chk("R9 mid reset data", m_tdata, 32'd0);
    run_image(0, 1'b0, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule